// File: doc/BRIEF.md
# Two-wire serial flash target

This block is the device end of a two-wire serial memory link. It has one serial clock input and one bidirectional data line, split here into an input, an output and an output enable. It runs on a faster system clock that oversamples both serial lines. The block has no select pin. A frame begins after the serial clock has been held low long enough, and the first rising edge after that wakes the target. Next comes a fixed header of 56 bits, sent MSB first. The target acts on the header only when the device address field matches its four strap inputs. Up to sixteen targets can therefore share one link.

A read returns a 16-bit Ready/Busy word and then a full sector of 264 bytes. An erase/write takes in a full sector and is finished by a long clock-low hold. After that the target reports busy for a fixed number of system clocks. Sector contents live in a small on-chip store. A read-only information sector is generated from logic. Holding the serial clock high pauses a frame for as long as needed.

Top module: `sflash_target`

## Requirements
- R1: After reset the output enable is low. Every sector reads C9H in byte 0 and FFH in every other byte. A read then reports the ready word 9999H.
- R2: The first rising serial edge after a frame reset only wakes the target, and the data on that edge is ignored. The next 56 rising edges carry the header, MSB first: command [4], sector address [12], device address [4], auxiliary address [4], then 32 reserved bits.
- R3: When the header's device address differs from the strap inputs, the target never drives the data line and leaves its store unchanged.
- R4: For a read (command 1H, auxiliary 0H), the output enable rises at the first falling serial edge after the header. The target then gives 16 status bits followed by 2112 data bits, MSB first, one bit per falling edge, valid at the next rising edge.
- R5: An erase/write (command 2H, auxiliary 0H) stores the 264 received bytes. They can be read back intact once the busy period has ended.
- R6: The frame reset that ends a write starts a busy period of BUSY_CYCLES system clocks. During that period a read reports 6666H and drives zero data bits. After the period it reports 9999H.
- R7: A write header that arrives while the target is busy is ignored.
- R8: When a write ends before all 264 bytes have arrived, every unreceived byte of that sector, including any partly received byte, becomes E5H.
- R9: Auxiliary address 5H reads the information sector. Its byte 0 is C9H and byte i is the low 8 bits of i XOR 5AH. A write with auxiliary 5H changes nothing and starts no busy period.
- R10: Holding the serial clock high for any length of time keeps the frame's state.
- R11: A command other than 1H or 2H makes the target stay silent until the next frame reset.
- R12: The output enable stays on while the clock is low for less than RESET_CYCLES system clocks. It turns off within a few clocks once the clock has been low for RESET_CYCLES.
- R13: A sector address selects store sector (address mod NUM_SECTORS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host |
| sio_i | input | 1 | Data line as seen by the target |
| dev_addr_i | input | 4 | Strapped device address |
| sio_o | output | 1 | Data driven by the target |
| sio_oe_o | output | 1 | Enable for the data line driver |

## Verification
The hardest case to reach is a header that lands inside the busy window. The commit only starts when the host holds the clock low. The bench then has to finish a status read and a second write header before BUSY_CYCLES run out. The bench leaves the target idle for no longer than needed, so that both arrive in time. Partial writes are finished early by a clock-low hold, and the marker fill is then read back through the normal read sequence.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam int HDR_BITS  = 56;
  localparam int HDR_KEEP  = 24;
  localparam int STAT_BITS = 16;

  localparam logic [3:0]  CMD_READ  = 4'h1;
  localparam logic [3:0]  CMD_WRITE = 4'h2;
  localparam logic [3:0]  AUX_MAIN  = 4'h0;
  localparam logic [3:0]  AUX_INFO  = 4'h5;
  localparam logic [15:0] WORD_READY = 16'h9999;
  localparam logic [15:0] WORD_BUSY  = 16'h6666;
  localparam logic [7:0]  TAG_BYTE   = 8'hC9;
  localparam logic [7:0]  ERASED     = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_READ, ST_WDATA, ST_WTAIL, ST_SKIP
  } state_t;

  function automatic logic [7:0] info_byte(input logic [15:0] idx);
    return (idx == 16'd0) ? TAG_BYTE : (idx[7:0] ^ 8'h5A);
  endfunction
endpackage

// File: rtl/sflash_frontend.sv
module sflash_frontend #(
  parameter int RESET_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sio_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sio_sync_o,
  output logic frame_rst_o
);
  localparam int LOW_W = $clog2(RESET_CYCLES + 1);

  logic [2:0] sck_q;
  logic [1:0] sio_q;
  logic [LOW_W-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      sio_q <= '0;
      low_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck_i};
      sio_q <= {sio_q[0], sio_i};
      if (sck_q[1]) low_q <= '0;
      else if (low_q != LOW_W'(RESET_CYCLES)) low_q <= low_q + 1'b1;
    end
  end

  assign sck_rise_o  = sck_q[1] & ~sck_q[2];
  assign sck_fall_o  = ~sck_q[1] & sck_q[2];
  assign sio_sync_o  = sio_q[1];
  // one pulse per long low hold
  assign frame_rst_o = ~sck_q[1] && (low_q == LOW_W'(RESET_CYCLES - 1));
endmodule

// File: rtl/sflash_store.sv
module sflash_store import sflash_pkg::*; #(
  parameter int NUM_SECTORS  = 4,
  parameter int SECTOR_BYTES = 264,
  parameter int SEC_W        = 2,
  parameter int BYTE_W       = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEC_W-1:0]  wsec_i,
  input  logic [BYTE_W-1:0] wbyte_i,
  input  logic [7:0]        wdata_i,
  input  logic [SEC_W-1:0]  rsec_i,
  input  logic [BYTE_W-1:0] rbyte_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = NUM_SECTORS * SECTOR_BYTES;
  localparam int IDX_W = $clog2(DEPTH);

  logic [7:0] mem_q [DEPTH];
  int widx, ridx;

  assign widx = int'(wsec_i) * SECTOR_BYTES + int'(wbyte_i);
  assign ridx = int'(rsec_i) * SECTOR_BYTES + int'(rbyte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[IDX_W'(i)] <= ((i % SECTOR_BYTES) == 0) ? TAG_BYTE : ERASED;
    end else if (we_i && widx < DEPTH) begin
      mem_q[IDX_W'(widx)] <= wdata_i;
    end
  end

  assign rdata_o = (int'(rbyte_i) < SECTOR_BYTES && ridx < DEPTH) ? mem_q[IDX_W'(ridx)] : 8'h00;
endmodule

// File: rtl/sflash_target.sv
module sflash_target import sflash_pkg::*; #(
  parameter int         NUM_SECTORS  = 4,
  parameter int         SECTOR_BYTES = 264,
  parameter int         RESET_CYCLES = 64,
  parameter int         BUSY_CYCLES  = 2000,
  parameter logic [7:0] FILL_BYTE    = 8'hE5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       sio_i,
  input  logic [3:0] dev_addr_i,
  output logic       sio_o,
  output logic       sio_oe_o
);
  localparam int DATA_BITS = SECTOR_BYTES * 8;
  localparam int OUT_BITS  = DATA_BITS + STAT_BITS;
  localparam int CNT_W     = $clog2(OUT_BITS + 1);
  localparam int BYTE_W    = $clog2(SECTOR_BYTES);
  localparam int SEC_W     = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1;
  localparam int BUSY_W    = $clog2(BUSY_CYCLES + 1);

  logic sck_rise, sck_fall, sio_s, frame_rst;

  sflash_frontend #(.RESET_CYCLES(RESET_CYCLES)) u_fe (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .sio_i(sio_i),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .sio_sync_o(sio_s), .frame_rst_o(frame_rst)
  );

  state_t             state_q;
  logic [5:0]         bit_q;
  logic [23:0]        hdr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [7:0]         wsh_q;
  logic [SEC_W-1:0]   sec_q, fill_sec_q;
  logic [BYTE_W-1:0]  fill_q;
  logic               fill_act_q, info_q, busy_stat_q, oe_q, do_q;
  logic [BUSY_W-1:0]  busy_q;

  logic [3:0]  h_cmd, h_dev, h_aux;
  logic [11:0] h_sect;
  assign {h_cmd, h_sect, h_dev, h_aux} = hdr_q;

  logic busy_nz, busy;
  assign busy_nz = busy_q != '0;
  assign busy    = busy_nz | fill_act_q;

  // read path: next bit index to present
  logic [CNT_W-1:0]  out_nxt, dbit;
  logic [BYTE_W-1:0] rd_byte;
  logic [7:0]        rd_mem, byte_v;
  logic [15:0]       stat_w;
  logic              bit_v;

  assign out_nxt = oe_q ? cnt_q + 1'b1 : '0;
  assign dbit    = out_nxt - CNT_W'(STAT_BITS);
  assign rd_byte = BYTE_W'(dbit >> 3);
  assign stat_w  = busy_stat_q ? WORD_BUSY : WORD_READY;
  assign byte_v  = busy_stat_q ? 8'h00 : (info_q ? info_byte(16'(rd_byte)) : rd_mem);
  assign bit_v   = (out_nxt < CNT_W'(STAT_BITS)) ? stat_w[4'd15 - out_nxt[3:0]]
                                                 : byte_v[3'd7 - dbit[2:0]];

  // write path
  logic [7:0]        wr_byte_v, st_wdata;
  logic              data_we, st_we;
  logic [SEC_W-1:0]  st_wsec;
  logic [BYTE_W-1:0] st_wbyte;

  assign wr_byte_v = {wsh_q[6:0], sio_s};
  assign data_we   = (state_q == ST_WDATA) && sck_rise && (cnt_q[2:0] == 3'd7);
  assign st_we     = fill_act_q | data_we;
  assign st_wsec   = fill_act_q ? fill_sec_q : sec_q;
  assign st_wbyte  = fill_act_q ? fill_q : BYTE_W'(cnt_q >> 3);
  assign st_wdata  = fill_act_q ? FILL_BYTE : wr_byte_v;

  sflash_store #(
    .NUM_SECTORS(NUM_SECTORS), .SECTOR_BYTES(SECTOR_BYTES),
    .SEC_W(SEC_W), .BYTE_W(BYTE_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(st_we), .wsec_i(st_wsec), .wbyte_i(st_wbyte), .wdata_i(st_wdata),
    .rsec_i(sec_q), .rbyte_i(rd_byte), .rdata_o(rd_mem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  bit_q <= '0;      hdr_q <= '0;
      cnt_q <= '0;         wsh_q <= '0;      sec_q <= '0;
      fill_sec_q <= '0;    fill_q <= '0;     fill_act_q <= 1'b0;
      info_q <= 1'b0;      busy_stat_q <= 1'b0;
      oe_q <= 1'b0;        do_q <= 1'b0;     busy_q <= '0;
    end else begin
      if (busy_nz) busy_q <= busy_q - 1'b1;
      if (fill_act_q) begin
        if (fill_q == BYTE_W'(SECTOR_BYTES - 1)) fill_act_q <= 1'b0;
        else fill_q <= fill_q + 1'b1;
      end
      if (frame_rst) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        if (state_q == ST_WDATA) begin
          fill_act_q <= 1'b1;
          fill_q     <= BYTE_W'(cnt_q >> 3);
          fill_sec_q <= sec_q;
        end
        if (state_q == ST_WDATA || state_q == ST_WTAIL) busy_q <= BUSY_W'(BUSY_CYCLES);
      end else begin
        unique case (state_q)
          ST_IDLE: if (sck_rise) begin
            state_q <= ST_HDR;
            bit_q   <= '0;
          end
          ST_HDR: if (sck_rise) begin
            if (bit_q < 6'(HDR_KEEP)) hdr_q <= {hdr_q[22:0], sio_s};
            bit_q <= bit_q + 1'b1;
            if (bit_q == 6'(HDR_BITS - 1)) begin
              sec_q  <= h_sect[SEC_W-1:0];
              info_q <= (h_aux == AUX_INFO);
              cnt_q  <= '0;
              if (h_dev != dev_addr_i) state_q <= ST_SKIP;
              else if (h_cmd == CMD_READ && (h_aux == AUX_MAIN || h_aux == AUX_INFO)) begin
                state_q     <= ST_READ;
                busy_stat_q <= busy;
              end else if (h_cmd == CMD_WRITE && h_aux == AUX_MAIN && !busy)
                state_q <= ST_WDATA;
              else state_q <= ST_SKIP;
            end
          end
          ST_READ: if (sck_fall) begin
            if (!oe_q) begin
              oe_q  <= 1'b1;
              cnt_q <= '0;
              do_q  <= bit_v;
            end else if (cnt_q != CNT_W'(OUT_BITS - 1)) begin
              cnt_q <= out_nxt;
              do_q  <= bit_v;
            end
          end
          ST_WDATA: if (sck_rise) begin
            wsh_q <= wr_byte_v;
            if (cnt_q == CNT_W'(DATA_BITS - 1)) begin
              state_q <= ST_WTAIL;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign sio_o    = do_q;
  assign sio_oe_o = oe_q;
endmodule

// File: rtl/sflash_target_chk.sv
module sflash_target_chk import sflash_pkg::*; (
  input logic   clk_i,
  input logic   rst_ni,
  input logic   sio_oe_o,
  input logic   sck_rise,
  input logic   sck_fall,
  input logic   frame_rst,
  input logic   busy_nz,
  input state_t state_q
);
  // R4
  oe_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sio_oe_o) |-> $past(sck_fall));

  // R12
  oe_off_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rst |=> !sio_oe_o);

  // R3
  oe_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_oe_o |-> (state_q == ST_READ));

  // R6
  busy_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_nz) |-> $past(frame_rst));

  // R2
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HDR && $past(state_q) == ST_IDLE) |-> $past(sck_rise));
endmodule

bind sflash_target sflash_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sio_oe_o(sio_oe_o),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .frame_rst(frame_rst),
  .busy_nz(busy_nz), .state_q(state_q)
);

// File: tb/sim_sflash_target.sv
module sim_sflash_target;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic sio = 1'b0;
  logic [3:0] dev = 4'hA;
  logic sio_out, sio_oe;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  sflash_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sio_i(sio),
    .dev_addr_i(dev), .sio_o(sio_out), .sio_oe_o(sio_oe)
  );

  logic [7:0]  rd_buf [264];
  logic [15:0] rd_stat;
  logic        oe_hdr, oe_all, oe_any;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * 7 + seed) & 255);
  endfunction

  task automatic bit_tx(input logic b);
    sck = 1'b0; sio = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bit_rx(output logic b);
    sck = 1'b0;
    repeat (4) @(negedge clk);
    b = sio_out;
    oe_all = oe_all & sio_oe;
    oe_any = oe_any | sio_oe;
    sck = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_end();
    sck = 1'b0;
    repeat (100) @(negedge clk);
  endtask

  task automatic start(input logic [3:0] cmd, input logic [11:0] sect,
                       input logic [3:0] da, input logic [3:0] aux);
    logic [23:0] h;
    h = {cmd, sect, da, aux};
    frame_end();
    sio = 1'b1;  // wake edge data is ignored
    sck = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 23; i >= 0; i--) bit_tx(h[i]);
    for (int i = 0; i < 32; i++) bit_tx(1'b0);
    oe_hdr = sio_oe;
  endtask

  task automatic rd(input logic [3:0] cmd, input logic [11:0] sect, input logic [3:0] da,
                    input logic [3:0] aux, input int nbytes, input int pause);
    logic b;
    oe_all = 1'b1; oe_any = 1'b0;
    start(cmd, sect, da, aux);
    for (int i = 15; i >= 0; i--) begin
      bit_rx(b);
      rd_stat[i] = b;
    end
    repeat (pause) @(negedge clk);
    for (int k = 0; k < nbytes; k++)
      for (int i = 7; i >= 0; i--) begin
        bit_rx(b);
        rd_buf[k][i] = b;
      end
  endtask

  task automatic wr(input logic [11:0] sect, input logic [3:0] da, input logic [3:0] aux,
                    input int nbytes, input int seed, input logic tail);
    logic [7:0] v;
    start(4'h2, sect, da, aux);
    for (int k = 0; k < nbytes; k++) begin
      v = pat(seed, k);
      for (int i = 7; i >= 0; i--) bit_tx(v[i]);
    end
    if (tail) for (int i = 0; i < 16; i++) bit_tx(1'b0);
    frame_end();
  endtask

  task automatic t_reset();
    chk("R1 oe after reset", 32'(sio_oe), 0);
    rd(4'h1, 12'h000, dev, 4'h0, 264, 0);
    chk("R1 ready word", 32'(rd_stat), 32'h9999);
    chk("R1 tag byte", 32'(rd_buf[0]), 32'hC9);
    chk("R1 erased byte 100", 32'(rd_buf[100]), 32'hFF);
    chk("R1 erased byte 263", 32'(rd_buf[263]), 32'hFF);
    chk("R4 oe off through header", 32'(oe_hdr), 0);
    chk("R4 oe on through data", 32'(oe_all), 1);
    chk("R2 header decoded after wake", 32'(oe_any), 1);
  endtask

  task automatic t_write_busy();
    int bad;
    wr(12'h002, dev, 4'h0, 264, 3, 1'b1);
    rd(4'h1, 12'h002, dev, 4'h0, 1, 0);
    chk("R6 busy word", 32'(rd_stat), 32'h6666);
    chk("R6 busy data zero", 32'(rd_buf[0]), 0);
    wr(12'h003, dev, 4'h0, 4, 11, 1'b0);  // R7 lands inside busy window
    repeat (2500) @(negedge clk);
    rd(4'h1, 12'h002, dev, 4'h0, 264, 0);
    chk("R6 ready after busy", 32'(rd_stat), 32'h9999);
    bad = 0;
    for (int k = 0; k < 264; k++) if (rd_buf[k] !== pat(3, k)) bad++;
    chk("R5 full sector mismatches", 32'(bad), 0);
    chk("R5 byte 263", 32'(rd_buf[263]), 32'(pat(3, 263)));
    rd(4'h1, 12'h003, dev, 4'h0, 2, 0);
    chk("R7 ignored write byte0", 32'(rd_buf[0]), 32'hC9);
    chk("R7 ignored write byte1", 32'(rd_buf[1]), 32'hFF);
  endtask

  task automatic t_partial();
    wr(12'h005, dev, 4'h0, 3, 9, 1'b0);
    repeat (2500) @(negedge clk);
    rd(4'h1, 12'h001, dev, 4'h0, 6, 0);
    chk("R13 alias sector byte0", 32'(rd_buf[0]), 32'(pat(9, 0)));
    chk("R8 received byte2", 32'(rd_buf[2]), 32'(pat(9, 2)));
    chk("R8 marker byte3", 32'(rd_buf[3]), 32'hE5);
    chk("R8 marker byte5", 32'(rd_buf[5]), 32'hE5);
  endtask

  task automatic t_info();
    rd(4'h1, 12'h000, dev, 4'h5, 8, 0);
    chk("R9 info byte0", 32'(rd_buf[0]), 32'hC9);
    chk("R9 info byte1", 32'(rd_buf[1]), 32'h5B);
    chk("R9 info byte7", 32'(rd_buf[7]), 32'h5D);
    wr(12'h000, dev, 4'h5, 2, 1, 1'b0);
    rd(4'h1, 12'h000, dev, 4'h5, 2, 0);
    chk("R9 no busy after info write", 32'(rd_stat), 32'h9999);
    chk("R9 info unchanged", 32'(rd_buf[1]), 32'h5B);
  endtask

  task automatic t_mismatch();
    rd(4'h1, 12'h000, 4'h3, 4'h0, 2, 0);
    chk("R3 silent on other address", 32'(oe_any), 0);
    wr(12'h000, 4'h3, 4'h0, 264, 5, 1'b1);
    rd(4'h1, 12'h000, dev, 4'h0, 2, 0);
    chk("R3 no busy", 32'(rd_stat), 32'h9999);
    chk("R3 store unchanged", 32'(rd_buf[1]), 32'hFF);
  endtask

  task automatic t_badcmd();
    rd(4'h3, 12'h000, dev, 4'h0, 2, 0);
    chk("R11 unknown command silent", 32'(oe_any), 0);
  endtask

  task automatic t_pause();
    rd(4'h1, 12'h002, dev, 4'h0, 4, 3000);
    chk("R10 status after pause", 32'(rd_stat), 32'h9999);
    chk("R10 byte0 after pause", 32'(rd_buf[0]), 32'(pat(3, 0)));
    chk("R10 byte3 after pause", 32'(rd_buf[3]), 32'(pat(3, 3)));
  endtask

  task automatic t_oe_drop();
    rd(4'h1, 12'h000, dev, 4'h0, 1, 0);
    sck = 1'b0;
    repeat (30) @(negedge clk);
    chk("R12 oe held on short low", 32'(sio_oe), 1);
    repeat (60) @(negedge clk);
    chk("R12 oe off after reset interval", 32'(sio_oe), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_busy();
    t_partial();
    t_info();
    t_mismatch();
    t_badcmd();
    t_pause();
    t_oe_drop();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule